// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the register side of a real-time clock. Software reaches 128 byte locations through a two-address port. A write to the even address selects a location, and the odd address then reads or writes that location. The block holds the four control and status registers, the three alarm bytes, the seven time and date bytes and general storage. It also gives register accesses their side effects: bits that cannot be written, a status byte that clears when read, and a set mode that stops the running clock from changing the time bytes.

A periodic divider and a calendar updater sit next to the block. They raise single-cycle event requests that set status flags, and the block drives a level interrupt from the flags that are enabled. The calendar arithmetic is outside the block. The block sends the time bytes out with a one-cycle load pulse when software changes the time, and it takes a fresh copy back on each update-done request.

Top module: `rtcIndexedRegs`

## Requirements
- R1: A write to address 0 stores the low 7 data bits as the index, so the top data bit is dropped. A read at address 0 returns 0xFF. At address 1, reads and writes reach the byte at the current index, and general storage keeps whatever was written to it.
- R2: After power-on reset, control A (index 10) reads 0x26, control B (index 11) reads 0x02, status C (index 12) reads 0x00 and status D (index 13) reads 0x80.
- R3: Writes to status C and status D do not change them.
- R4: A write to control A sets bits 6..0 from the data and leaves bit 7, the update-in-progress flag, as it was.
- R5: A write to control B with bit 7 (set mode) high stores the data with bit 4 (update interrupt enable) forced to 0, and it clears update-in-progress in control A.
- R6: A write to control B with bit 7 low, when bit 7 was high before, raises loadCal for one cycle in the next cycle. At that point timeOut holds the current time bytes.
- R7: A write to a time byte raises loadCal in the next cycle only when set mode is off. In set mode no load pulse appears.
- R8: A read of status C returns its value. Status C is 0x00 from the next cycle on, and irq is low, unless an event arrives in that same cycle.
- R9: Soft reset clears control B bits 6, 5 and 3 (periodic, alarm and square-wave enables). It clears status C and lowers irq, and it leaves the other bits of control B as they were.
- R10: perEvt, alarmEvt and updDone set status C bits 6, 5 and 4. Bit 7 of status C and irq equal the OR of each flag ANDed with its enable in control B (bits 6, 5 and 4), and both are registered one cycle after the cause.
- R11: An event that arrives in the same cycle as a status C read stays set after the clear.
- R12: Time byte k (k = 0..6) sits at index 0, 2, 4, 6, 7, 8, 9 and maps to bits 8k+7..8k of timeIn and timeOut. updStart sets update-in-progress when set mode is off. updDone clears update-in-progress and sets bit 4 of status C. When set mode is off, updDone also copies timeIn into the time bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Synchronous power-on reset, active low |
| rstN | input | 1 | Synchronous soft reset, active low |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| perEvt | input | 1 | Periodic divider tick |
| alarmEvt | input | 1 | Alarm match request |
| updStart | input | 1 | Calendar update begins |
| updDone | input | 1 | Calendar update complete, timeIn valid |
| timeIn | input | 56 | New time bytes from the updater |
| timeOut | output | 56 | Current time bytes |
| loadCal | output | 1 | One-cycle request to load timeOut into the calendar |
| ctlAOut | output | 8 | Control A contents (rate and divider fields for neighbours) |
| ctlBOut | output | 8 | Control B contents |
| irq | output | 1 | Level interrupt |

## Verification
A wrong flag or enable bit shows up on irq one cycle after the event or register write that caused it. A status byte that failed to clear shows up on the next read of index 12. A bad set-mode state shows up as a missing or extra loadCal pulse one cycle after the write to a time byte or to control B. It also shows up as time bytes on timeOut that did or did not take the timeIn copy. A behavioural model follows every cycle, so a wrong state is caught at the edge where it first shows at a port, not only at a later read-back.

// File: rtl/rtcRegPkg.sv
package rtcRegPkg;
  localparam int DATA_W      = 8;
  localparam int IDX_W       = 7;
  localparam int NUM_TIME    = 7;
  localparam int STORE_DEPTH = 1 << IDX_W;
  localparam int TIME_W      = NUM_TIME * DATA_W;

  localparam logic [IDX_W-1:0] IDX_CTLA = 7'd10;
  localparam logic [IDX_W-1:0] IDX_CTLB = 7'd11;
  localparam logic [IDX_W-1:0] IDX_STAT = 7'd12;
  localparam logic [IDX_W-1:0] IDX_VLD  = 7'd13;

  localparam int A_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;
  localparam int C_IRQF = 7;
  localparam int C_PF   = 6;
  localparam int C_UF   = 4;

  localparam logic [DATA_W-1:0] PWR_A   = 8'h26;
  localparam logic [DATA_W-1:0] PWR_B   = 8'h02;
  localparam logic [DATA_W-1:0] PWR_C   = 8'h00;
  localparam logic [DATA_W-1:0] FIXED_D = 8'h80;
  localparam logic [DATA_W-1:0] EVEN_RD = 8'hFF;

  typedef struct packed {
    logic wrStore;
    logic wrTime;
    logic wrCtlA;
    logic wrCtlB;
    logic rdStat;
  } regStrobe_t;

  function automatic logic [IDX_W-1:0] timeSlot(input int k);
    if (k < 3) return IDX_W'(2 * k);
    else       return IDX_W'(k + 3);
  endfunction

  function automatic logic isTimeSlot(input logic [IDX_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NUM_TIME; k++) begin
      if (idx == timeSlot(k)) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/rtcAccessCtl.sv
module rtcAccessCtl
  import rtcRegPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              setNow,
  output logic [IDX_W-1:0]  curIdx,
  output regStrobe_t        strb,
  output logic              loadCal
);
  logic dataWr, dataRd, idxWr, isCtl, timeHit, leaveSet, loadNext;

  always_comb begin
    idxWr   = busSel & busWr & ~busAddr & rstN;
    dataWr  = busSel & busWr & busAddr & rstN;
    dataRd  = busSel & ~busWr & busAddr & rstN;
    timeHit = isTimeSlot(curIdx);
    isCtl   = (curIdx == IDX_CTLA) | (curIdx == IDX_CTLB) |
              (curIdx == IDX_STAT) | (curIdx == IDX_VLD);
    strb.wrCtlA  = dataWr & (curIdx == IDX_CTLA);
    strb.wrCtlB  = dataWr & (curIdx == IDX_CTLB);
    strb.wrTime  = dataWr & timeHit;
    strb.wrStore = dataWr & ~isCtl & ~timeHit;
    strb.rdStat  = dataRd & (curIdx == IDX_STAT);
    leaveSet = strb.wrCtlB & ~busWdata[B_SET] & setNow;
    loadNext = (strb.wrTime & ~setNow) | leaveSet;
  end

  always_ff @(posedge clk) begin
    if (!porN)      curIdx <= '0;
    else if (idxWr) curIdx <= busWdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) loadCal <= 1'b0;
    else                loadCal <= loadNext;
  end

  // R7
  load_has_cause_chk: assert property (@(posedge clk) disable iff (!porN)
    loadCal |-> $past(busSel & busWr & busAddr));
  // R7
  no_load_in_set_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.wrTime & setNow) |=> !loadCal);
endmodule

// File: rtl/rtcRegBank.sv
module rtcRegBank
  import rtcRegPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              perEvt,
  input  logic              alarmEvt,
  input  logic              updStart,
  input  logic              updDone,
  input  logic [TIME_W-1:0] timeIn,
  output logic [TIME_W-1:0] timeOut,
  output logic [DATA_W-1:0] ctlA,
  output logic [DATA_W-1:0] ctlB,
  output logic              setNow,
  output logic              irq
);
  logic [DATA_W-1:0] store [STORE_DEPTH];
  logic [DATA_W-1:0] ctlC;
  logic              uipNx, irqfNx;
  logic [6:0]        aLowNx;
  logic [DATA_W-1:0] bNx;
  logic [2:0]        flagsNx;

  assign setNow = ctlB[B_SET];
  assign irq    = ctlC[C_IRQF];

  always_ff @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < STORE_DEPTH; i++) store[i] <= '0;
    end else if (rstN) begin
      if (updDone && !setNow) begin
        for (int k = 0; k < NUM_TIME; k++)
          store[timeSlot(k)] <= timeIn[k*DATA_W +: DATA_W];
      end
      if (strb.wrStore || strb.wrTime) store[curIdx] <= busWdata;
    end
  end

  for (genvar k = 0; k < NUM_TIME; k++) begin : gTime
    assign timeOut[k*DATA_W +: DATA_W] = store[timeSlot(k)];
  end

  always_comb begin
    uipNx = ctlA[A_UIP];
    if (updStart && !setNow) uipNx = 1'b1;
    if (updDone) uipNx = 1'b0;
    if (strb.wrCtlB && busWdata[B_SET]) uipNx = 1'b0;
    aLowNx = strb.wrCtlA ? busWdata[6:0] : ctlA[6:0];
    bNx = ctlB;
    if (strb.wrCtlB) begin
      bNx = busWdata;
      if (busWdata[B_SET]) bNx[B_UIE] = 1'b0;
    end
    flagsNx = strb.rdStat ? 3'b000 : ctlC[C_PF:C_UF];
    flagsNx = flagsNx | {perEvt, alarmEvt, updDone};
    irqfNx  = |(flagsNx & bNx[B_PIE:B_UIE]);
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      ctlA <= PWR_A;
      ctlB <= PWR_B;
      ctlC <= PWR_C;
    end else if (!rstN) begin
      ctlB[B_PIE]  <= 1'b0;
      ctlB[B_AIE]  <= 1'b0;
      ctlB[B_SQWE] <= 1'b0;
      ctlC         <= '0;
    end else begin
      ctlA <= {uipNx, aLowNx};
      ctlB <= bNx;
      ctlC <= {irqfNx, flagsNx, 4'b0000};
    end
  end

  always_comb begin
    if (!busAddr) busRdata = EVEN_RD;
    else begin
      case (curIdx)
        IDX_CTLA: busRdata = ctlA;
        IDX_CTLB: busRdata = ctlB;
        IDX_STAT: busRdata = ctlC;
        IDX_VLD:  busRdata = FIXED_D;
        default:  busRdata = store[curIdx];
      endcase
    end
  end

  // R4
  uip_kept_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.wrCtlA & ~updStart & ~updDone) |=>
      (ctlA[A_UIP] == $past(ctlA[A_UIP])) && (ctlA[6:0] == $past(busWdata[6:0])));
  // R5
  set_entry_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.wrCtlB & busWdata[B_SET]) |=> (!ctlB[B_UIE] && !ctlA[A_UIP]));
  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.rdStat & ~perEvt & ~alarmEvt & ~updDone) |=> (ctlC == '0) && !irq);
  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (ctlC == '0) && !ctlB[B_PIE] && !ctlB[B_AIE] && !ctlB[B_SQWE]);
  // R10
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!porN)
    irq |-> |(ctlC[C_PF:C_UF] & ctlB[B_PIE:B_UIE]));
  // R11
  flag_survives_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.rdStat & perEvt) |=> ctlC[C_PF]);
endmodule

// File: rtl/rtcIndexedRegs.sv
module rtcIndexedRegs
  import rtcRegPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              perEvt,
  input  logic              alarmEvt,
  input  logic              updStart,
  input  logic              updDone,
  input  logic [TIME_W-1:0] timeIn,
  output logic [TIME_W-1:0] timeOut,
  output logic              loadCal,
  output logic [DATA_W-1:0] ctlAOut,
  output logic [DATA_W-1:0] ctlBOut,
  output logic              irq
);
  regStrobe_t       strb;
  logic [IDX_W-1:0] curIdx;
  logic             setNow;

  rtcAccessCtl uCtl (
    .clk(clk), .porN(porN), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .setNow(setNow), .curIdx(curIdx), .strb(strb), .loadCal(loadCal)
  );

  rtcRegBank uBank (
    .clk(clk), .porN(porN), .rstN(rstN), .strb(strb), .curIdx(curIdx),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .perEvt(perEvt), .alarmEvt(alarmEvt), .updStart(updStart), .updDone(updDone),
    .timeIn(timeIn), .timeOut(timeOut), .ctlA(ctlAOut), .ctlB(ctlBOut),
    .setNow(setNow), .irq(irq)
  );
endmodule

// File: tb/tb_rtcIndexedRegs.sv
module tb_rtcIndexedRegs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic porN, rstN, busSel, busWr, busAddr;
  logic [7:0] busWdata, busRdata, ctlAOut, ctlBOut;
  logic perEvt, alarmEvt, updStart, updDone, loadCal, irq;
  logic [55:0] timeIn, timeOut;

  int nTests = 0;
  int nFail = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  logic [7:0] m [128];
  logic [6:0] mIdx;
  logic mIrq, mLoad;
  logic setOld, uip, ld, rdC, irqf;
  logic [2:0] fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcIndexedRegs dut (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .perEvt(perEvt), .alarmEvt(alarmEvt), .updStart(updStart), .updDone(updDone),
    .timeIn(timeIn), .timeOut(timeOut), .loadCal(loadCal),
    .ctlAOut(ctlAOut), .ctlBOut(ctlBOut), .irq(irq)
  );

  function automatic int tslot(input int k);
    return (k < 3) ? 2 * k : k + 3;
  endfunction

  function automatic bit isTime(input int idx);
    for (int k = 0; k < 7; k++) if (idx == tslot(k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [55:0] mTime();
    logic [55:0] t;
    for (int k = 0; k < 7; k++) t[k*8 +: 8] = m[tslot(k)];
    return t;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < 128; i++) m[i] = 8'h00;
      m[10] = 8'h26; m[11] = 8'h02; m[12] = 8'h00; m[13] = 8'h80;
      mIdx = 7'd0; mIrq = 1'b0; mLoad = 1'b0;
    end else if (!rstN) begin
      m[11] = m[11] & 8'h97;
      m[12] = 8'h00; mIrq = 1'b0; mLoad = 1'b0;
    end else begin
      setOld = m[11][7];
      uip = m[10][7];
      ld = 1'b0;
      rdC = busSel && !busWr && busAddr && (mIdx == 7'd12);
      fl = rdC ? 3'b000 : m[12][6:4];
      if (updStart && !setOld) uip = 1'b1;
      if (updDone) begin
        uip = 1'b0;
        if (!setOld) for (int k = 0; k < 7; k++) m[tslot(k)] = timeIn[k*8 +: 8];
      end
      if (busSel && busWr) begin
        if (!busAddr) mIdx = busWdata[6:0];
        else begin
          case (mIdx)
            7'd10: m[10][6:0] = busWdata[6:0];
            7'd11: begin
              if (busWdata[7]) begin m[11] = busWdata & 8'hEF; uip = 1'b0; end
              else begin if (setOld) ld = 1'b1; m[11] = busWdata; end
            end
            7'd12, 7'd13: ;
            default: begin
              m[mIdx] = busWdata;
              if (isTime(int'(mIdx)) && !setOld) ld = 1'b1;
            end
          endcase
        end
      end
      fl = fl | {perEvt, alarmEvt, updDone};
      irqf = |(fl & m[11][6:4]);
      m[12] = {irqf, fl, 4'b0000};
      m[10][7] = uip;
      mIrq = irqf;
      mLoad = ld;
    end
  end

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R10 irq", 64'(irq), 64'(mIrq));
      chk("R7 loadCal", 64'(loadCal), 64'(mLoad));
      chk("R12 timeOut", 64'(timeOut), 64'(mTime()));
      chk("R4 ctlA", 64'(ctlAOut), 64'(m[10]));
      chk("R5 ctlB", 64'(ctlBOut), 64'(m[11]));
    end
  end

  task automatic wrCyc(input logic a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic wrReg(input logic [6:0] idx, input logic [7:0] d);
    wrCyc(1'b0, {1'b0, idx});
    wrCyc(1'b1, d);
  endtask

  task automatic rdCur(input string tag);
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b1;
    #1;
    chk(tag, 64'(busRdata), 64'(m[mIdx]));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rdCheck(input logic [6:0] idx, input string tag);
    wrCyc(1'b0, {1'b0, idx});
    rdCur(tag);
  endtask

  task automatic evt(input logic p, input logic a, input logic s, input logic d,
                     input logic [55:0] t);
    perEvt = p; alarmEvt = a; updStart = s; updDone = d; timeIn = t;
    @(negedge clk);
    perEvt = 1'b0; alarmEvt = 1'b0; updStart = 1'b0; updDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    porN = 1'b0; rstN = 1'b1; busSel = 1'b0; busWr = 1'b0; busAddr = 1'b0;
    busWdata = 8'h00; perEvt = 1'b0; alarmEvt = 1'b0; updStart = 1'b0;
    updDone = 1'b0; timeIn = '0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    started = 1'b1;

    // R2 power-up values
    rdCheck(7'd10, "R2 ctlA power-up");
    chk("R2 ctlA literal", 64'(ctlAOut), 64'h26);
    rdCheck(7'd11, "R2 ctlB power-up");
    rdCheck(7'd12, "R2 statC power-up");
    rdCheck(7'd13, "R2 statD power-up");

    // R1 even read, index masking, general storage
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b0;
    #1 chk("R1 even read", 64'(busRdata), 64'hFF);
    @(negedge clk); busSel = 1'b0;
    wrReg(7'h20, 8'h5A);
    rdCheck(7'h20, "R1 storage readback");
    wrCyc(1'b0, 8'hAE);
    wrCyc(1'b1, 8'h33);
    rdCur("R1 index top bit dropped");
    rdCheck(7'h2E, "R1 masked index");

    // R3 status writes ignored
    wrReg(7'd12, 8'hFF);
    rdCheck(7'd12, "R3 statC unwritable");
    wrReg(7'd13, 8'h00);
    rdCheck(7'd13, "R3 statD unwritable");

    // R4 control A keeps update-in-progress
    wrReg(7'd10, 8'hFF);
    rdCheck(7'd10, "R4 uip not writable");
    evt(1'b0, 1'b0, 1'b1, 1'b0, '0);
    wrReg(7'd10, 8'h05);
    rdCheck(7'd10, "R4 uip kept high");

    // R12 update copy outside set mode
    evt(1'b0, 1'b0, 1'b0, 1'b1, 56'h23_01_15_03_11_22_33);
    rdCheck(7'd4, "R12 hour copied");
    rdCheck(7'd10, "R12 uip cleared");
    rdCheck(7'd12, "R12 update flag");

    // R5 entering set mode
    evt(1'b0, 1'b0, 1'b1, 1'b0, '0);
    wrReg(7'd11, 8'h92);
    rdCheck(7'd11, "R5 uie forced low");
    rdCheck(7'd10, "R5 uip cleared");

    // R7 no load in set mode
    wrReg(7'd0, 8'h30);
    chk("R7 no load in set mode", 64'(loadCal), 64'h0);

    // R12 no copy and no uip while in set mode
    evt(1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R12 uip held in set mode", 64'(ctlAOut[7]), 64'h0);
    evt(1'b0, 1'b0, 1'b0, 1'b1, 56'h99_12_31_07_23_59_58);
    rdCheck(7'd0, "R12 no copy in set mode");

    // R6 leaving set mode
    wrReg(7'd11, 8'h02);
    chk("R6 load pulse", 64'(loadCal), 64'h1);
    chk("R6 seconds on timeOut", 64'(timeOut[7:0]), 64'h30);
    @(negedge clk);
    chk("R6 single pulse", 64'(loadCal), 64'h0);

    // R7 time write outside set mode
    wrReg(7'd2, 8'h45);
    chk("R7 load on time write", 64'(loadCal), 64'h1);
    chk("R7 minutes on timeOut", 64'(timeOut[15:8]), 64'h45);

    // R10 and R8 enabled flags drive irq, read clears
    rdCheck(7'd12, "R8 clear stale flags");
    wrReg(7'd11, 8'h42);
    evt(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R10 periodic irq", 64'(irq), 64'h1);
    evt(1'b0, 1'b1, 1'b0, 1'b0, '0);
    rdCheck(7'd12, "R10 alarm flag without enable");
    chk("R8 irq dropped", 64'(irq), 64'h0);
    rdCur("R8 statC cleared");

    // R11 event at the read survives
    evt(1'b1, 1'b0, 1'b0, 1'b0, '0);
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b1; perEvt = 1'b1;
    #1 chk("R11 read returns old", 64'(busRdata), 64'(m[12]));
    @(negedge clk);
    busSel = 1'b0; perEvt = 1'b0;
    chk("R11 irq still high", 64'(irq), 64'h1);
    rdCur("R11 flag survived");

    // R9 soft reset
    wrReg(7'd11, 8'h7A);
    evt(1'b0, 1'b1, 1'b0, 1'b0, '0);
    chk("R9 irq before reset", 64'(irq), 64'h1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R9 irq lowered", 64'(irq), 64'h0);
    rdCheck(7'd11, "R9 enables cleared");
    chk("R9 ctlB literal", 64'(ctlBOut), 64'h12);
    rdCheck(7'd12, "R9 statC cleared");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule